// File: doc/BRIEF.md
# Prioritized Bus Ownership Arbiter

This block decides which of several DMA-style masters may drive a shared system bus. Each master raises its own request line. The arbiter offers a grant to the requester with the highest fixed priority. Ownership is not locked until the offered master answers with an acknowledge. From then on, no other request has any effect until that acknowledge drops. A processor takes part without a request line. It holds the bus by default whenever no grant is active. A status output reports this.

The arbiter runs entirely from one clock. Request and acknowledge inputs pass through a register stage before any decision uses them. Grant and processor-ownership outputs are also registered. A level change on an input pin therefore reaches the outputs two rising edges later. When a transfer ends and another request is already waiting, the arbiter moves the grant straight to the new master. The processor gets no cycle in between, so transfers can run back to back.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant_out` is all zeros and `host_owns` is 1.
- R2: From idle, the arbiter offers the grant to the lowest-numbered requesting master; bit 0 of `req_in` has the highest priority and bit N-1 the lowest. A grant bit rises two clock edges after its request pin rises.
- R3: `host_owns` is 1 exactly in the cycles in which every bit of `grant_out` is 0.
- R4: At most one bit of `grant_out` is 1 in any cycle.
- R5: While the owning master holds its acknowledge high, `grant_out` does not change, whatever other masters request.
- R6: When the owner drops its acknowledge and no request is pending, its grant bit clears and `host_owns` rises two edges after the acknowledge pin falls.
- R7: When the owner drops its acknowledge while another request is pending, the grant moves directly to the highest-priority pending master in the same cycle the old grant clears, with no cycle of processor ownership.
- R8: If an offered master drops its request before acknowledging, the grant is withdrawn on the next edge after the registered request falls, and the processor owns the bus again.
- R9: While a grant is offered but not yet acknowledged, requests of higher priority do not move the grant.
- R10: An acknowledge from a master that does not hold the grant has no effect on `grant_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N_MASTERS | Request lines, bit 0 highest priority |
| ack_in | input | N_MASTERS | Grant-acknowledge lines, one per master |
| grant_out | output | N_MASTERS | Registered one-hot grant, all zeros when the processor owns the bus |
| host_owns | output | 1 | Registered flag, 1 when the processor is the bus owner |

## Verification
The assertions rely on the masters following the handshake. A master raises its acknowledge only after it sees its own grant, and it drops its request in the same cycle. It keeps the request high until it is either granted or abandons the request. After releasing the acknowledge or abandoning, it ignores its grant line until the registered outputs have caught up. The random masters obey this through a per-master cool-down counter of three cycles after every release or abandon. The directed sequences drive protocol-violating acknowledges only where R10 asks for them, and only to check that they have no effect.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_HELD  = 2'd2
  } arb_state_t;
endpackage

// File: rtl/arb_inreg.sv
module arb_inreg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/arb_prio.sv
module arb_prio #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  pick_oh,
  output logic [IW-1:0] pick_idx,
  output logic          pick_any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick_oh[i]    = req[i] & ~blocked[i];
    assign blocked[i+1]  = blocked[i] | req[i];
  end

  assign pick_any = blocked[N];

  always_comb begin
    pick_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) pick_idx = IW'(i);
    end
  end

  always_comb begin
    AST_PICK_ONEHOT: assert ($onehot0(pick_oh)); // R4
  end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_q,
  input  logic [N-1:0]  ack_q,
  input  logic [N-1:0]  pick_oh,
  input  logic [IW-1:0] pick_idx,
  input  logic          pick_any,
  output logic [N-1:0]  gnt,
  output logic          host
);
  arb_state_t    st;
  logic [IW-1:0] own;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      own  <= '0;
      gnt  <= '0;
      host <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (pick_any) begin
            gnt  <= pick_oh;
            own  <= pick_idx;
            host <= 1'b0;
            st   <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (ack_q[own]) begin
            st <= ST_HELD;
          end else if (!req_q[own]) begin
            gnt  <= '0;
            host <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_HELD: begin
          if (!ack_q[own]) begin
            if (pick_any) begin
              gnt <= pick_oh;
              own <= pick_idx;
              st  <= ST_OFFER;
            end else begin
              gnt  <= '0;
              host <= 1'b1;
              st   <= ST_IDLE;
            end
          end
        end
        default: begin
          gnt  <= '0;
          host <= 1'b1;
          st   <= ST_IDLE;
        end
      endcase
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R4
  AST_HOST_FLAG: assert property (@(posedge clk) disable iff (rst)
    host == (gnt == '0)); // R3
  AST_FIRST_PICK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && pick_any) |=> (gnt == $past(pick_oh))); // R2
  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HELD && ack_q[own]) |=> $stable(gnt)); // R5
  AST_OFFER_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFFER && req_q[own]) |=> $stable(gnt)); // R9
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HELD && !ack_q[own] && !pick_any) |=> (host && gnt == '0)); // R6
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HELD && !ack_q[own] && pick_any) |=> (!host && gnt == $past(pick_oh))); // R7
  AST_ABANDON: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFFER && !ack_q[own] && !req_q[own]) |=> host); // R8
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N_MASTERS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req_in,
  input  logic [N_MASTERS-1:0] ack_in,
  output logic [N_MASTERS-1:0] grant_out,
  output logic                 host_owns
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0] req_q, ack_q, pick_oh;
  logic [IW-1:0]        pick_idx;
  logic                 pick_any;

  arb_inreg #(.W(N_MASTERS)) u_req_reg (.clk(clk), .rst(rst), .d(req_in), .q(req_q));
  arb_inreg #(.W(N_MASTERS)) u_ack_reg (.clk(clk), .rst(rst), .d(ack_in), .q(ack_q));

  arb_prio #(.N(N_MASTERS), .IW(IW)) u_prio (
    .req(req_q), .pick_oh(pick_oh), .pick_idx(pick_idx), .pick_any(pick_any)
  );

  arb_ctrl #(.N(N_MASTERS), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .req_q(req_q), .ack_q(ack_q),
    .pick_oh(pick_oh), .pick_idx(pick_idx), .pick_any(pick_any),
    .gnt(grant_out), .host(host_owns)
  );
endmodule

// File: tb/sim_bus_arbiter.sv
`timescale 1ns/1ps
module sim_bus_arbiter;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] ack = '0;
  logic [N-1:0] gnt;
  logic         host;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int           m_st  = 0;
  int           m_idx = 0;
  logic [N-1:0] m_gnt = '0;
  logic [N-1:0] m_rq  = '0;
  logic [N-1:0] m_aq  = '0;
  int           cool [N];

  always #2 clk = ~clk;

  bus_arbiter #(.N_MASTERS(N)) u0 (
    .clk(clk), .rst(rst), .req_in(req), .ack_in(ack),
    .grant_out(gnt), .host_owns(host)
  );

  function automatic int top_pick(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // expected registers after the coming rising edge
  task automatic model_step();
    int k;
    case (m_st)
      0: if (m_rq != '0) begin
           k = top_pick(m_rq); m_gnt = N'(1) << k; m_idx = k; m_st = 1;
         end
      1: if (m_aq[m_idx]) m_st = 2;
         else if (!m_rq[m_idx]) begin m_gnt = '0; m_st = 0; end
      default: if (!m_aq[m_idx]) begin
           if (m_rq != '0) begin
             k = top_pick(m_rq); m_gnt = N'(1) << k; m_idx = k; m_st = 1;
           end else begin
             m_gnt = '0; m_st = 0;
           end
         end
    endcase
    m_rq = req;
    m_aq = ack;
  endtask

  task automatic check_all(input string tag);
    checks++;
    if (gnt !== m_gnt) begin
      errors++;
      $display("FAIL %s grant actual=%b expected=%b", tag, gnt, m_gnt);
    end
    checks++;
    if (host !== (m_gnt == '0)) begin
      errors++;
      $display("FAIL %s R3 host actual=%b expected=%b", tag, host, (m_gnt == '0));
    end
    checks++;
    if ($countones(gnt) > 1) begin
      errors++;
      $display("FAIL R4 grant actual=%b expected=onehot0", gnt);
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] a, input string tag);
    req = r;
    ack = a;
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) cool[i] = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;
    drive('0, '0, "R1");

    // R2: masters 2 and 4 ask, 2 wins
    repeat (3) drive(5'b10100, '0, "R2");
    // R5: owner 2 acknowledges, then master 0 asks and is ignored
    repeat (2) drive(5'b10000, 5'b00100, "R5");
    repeat (3) drive(5'b10001, 5'b00100, "R5");
    // R7: release with 0 and 4 pending, grant jumps to 0 with no host cycle
    repeat (3) drive(5'b10001, '0, "R7");
    // R8: master 0 abandons before acknowledging, then 4 is picked
    repeat (2) drive(5'b10000, '0, "R8");
    // R9: 4 offered, master 1 asks, grant stays on 4
    repeat (3) drive(5'b10010, '0, "R9");
    // R10: stray acknowledge from master 3 leaves the offer alone
    repeat (3) drive(5'b10010, 5'b01000, "R10");
    // 4 takes the bus, 1 gives up, then release with nothing pending
    repeat (2) drive(5'b00010, 5'b10000, "R5");
    repeat (2) drive('0, 5'b10000, "R5");
    repeat (3) drive('0, '0, "R6");

    // constrained random masters obeying the handshake
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] r, a;
      r = req; a = ack;
      for (int i = 0; i < N; i++) begin
        if (cool[i] > 0) cool[i]--;
        else if (a[i]) begin
          if ($urandom % 4 == 0) begin a[i] = 1'b0; cool[i] = 3; end
        end else if (gnt[i] && r[i]) begin
          int s;
          s = $urandom % 8;
          if (s == 0) begin r[i] = 1'b0; cool[i] = 3; end
          else if (s < 6) begin a[i] = 1'b1; r[i] = 1'b0; end
        end else if (!r[i] && ($urandom % 6 == 0)) r[i] = 1'b1;
      end
      drive(r, a, "R2");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule